// File: doc/BRIEF.md
# DMA Transfer Address Generator

This block keeps the two running addresses of one DMA channel: the address on the peripheral side and the address on the memory side. A load pulse captures both start addresses together with the channel's per-side data widths, the two increment enables, the peripheral step override and the channel priority. From then on, every beat-done pulse moves each address forward by its step, or holds it where it is, as that captured configuration says.

The peripheral step is normally the peripheral data width: 1, 2 or 4 bytes. A single override bit fixes it at 4 bytes whatever the width is, so a narrow register can be reached at word-aligned strides. The memory step always follows the memory data width. Incrementing can be switched off on each side independently, which gives a fixed register address on one side and a buffer walk on the other. The priority is not used here. It is held from the load and handed to the channel arbiter unchanged.

Bus protocol, beat counting and FIFO packing live in neighbouring blocks. The block sees only the beat-done pulse.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, both address outputs and the priority output read zero.
- R2: A load pulse makes the peripheral and memory address outputs equal the start inputs from the next cycle on. If load and beat-done are high in the same cycle, load wins and the addresses show the start values unadvanced.
- R3: When the loaded peripheral increment enable is 0, beat-done pulses leave the peripheral address unchanged.
- R4: When the loaded memory increment enable is 0, beat-done pulses leave the memory address unchanged.
- R5: With the peripheral increment enable at 1 and the override bit at 0, each beat-done pulse adds the peripheral step given by the width code: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes, and the reserved code 3 gives 4 bytes.
- R6: With the peripheral increment enable at 1 and the override bit at 1, each beat-done pulse adds 4 to the peripheral address, for any width code.
- R7: With the memory increment enable at 1, each beat-done pulse adds the memory step given by the memory width code, using the same encoding as R5. The override bit has no effect on the memory side.
- R8: In a cycle with neither load nor beat-done, both addresses hold their values.
- R9: Addresses are 32 bits and wrap modulo 2^32 when a step carries past the top.
- R10: The 2-bit priority (0 low, 1 medium, 2 high, 3 very high) is captured on load and shown unchanged until the next load.
- R11: Changes to the width, increment, override, priority or start inputs without a load pulse have no effect. Beats use the configuration captured at the last load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture start addresses and configuration |
| per_start_i | input | 32 | Peripheral start address |
| mem_start_i | input | 32 | Memory start address |
| per_width_i | input | 2 | Peripheral data width code |
| mem_width_i | input | 2 | Memory data width code |
| per_inc_i | input | 1 | Peripheral increment enable |
| mem_inc_i | input | 1 | Memory increment enable |
| per_fix4_i | input | 1 | Fix peripheral step at 4 bytes |
| prio_i | input | 2 | Channel priority |
| beat_i | input | 1 | Beat-done pulse |
| per_addr_o | output | 32 | Current peripheral address |
| mem_addr_o | output | 32 | Current memory address |
| prio_o | output | 2 | Captured priority for the arbiter |

## Verification
The bench sweeps every combination of the two width codes, the two increment enables and the override bit, which is 128 configurations. Each one runs a short series of beats with idle cycles between them. Because the widths differ per side, a swapped width or a step taken from the wrong side gives a wrong address. Because the override bit is set against narrow widths, a width step and a fixed 4-byte step give different answers. Some start values sit just below 2^32 to show wrap-around, and the configuration inputs are changed right after each load to show that only loaded values count. A final case with load and beat-done in the same cycle shows that load takes precedence.

// File: rtl/dma_addr_gen_pkg.sv
package dma_addr_gen_pkg;

    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        WID_BYTE = 2'd0,
        WID_HALF = 2'd1,
        WID_WORD = 2'd2,
        WID_RSVD = 2'd3
    } wid_e;

    typedef struct packed {
        logic       per_inc;
        logic       mem_inc;
        logic       per_fix4;
        wid_e       per_wid;
        wid_e       mem_wid;
        logic [1:0] prio;
    } chan_cfg_t;

endpackage

// File: rtl/dma_step_sel.sv
module dma_step_sel
    import dma_addr_gen_pkg::*;
#(
    parameter int AW = 32
) (
    input  wid_e          wid_i,
    input  logic          fix4_i,
    input  logic          allow_fix_i,
    output logic [AW-1:0] step_o
);
    logic [2:0] bytes_w;

    always_comb begin
        unique case (wid_i)
            WID_BYTE: bytes_w = 3'd1;
            WID_HALF: bytes_w = 3'd2;
            default:  bytes_w = 3'd4;
        endcase
        if (allow_fix_i && fix4_i) begin
            bytes_w = 3'd4;
        end
        step_o = {{(AW-3){1'b0}}, bytes_w};
    end

endmodule

// File: rtl/dma_addr_lane.sv
module dma_addr_lane #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] start_i,
    input  logic          beat_i,
    input  logic          inc_i,
    input  logic [AW-1:0] step_i,
    output logic [AW-1:0] addr_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.addr = start_i;
        end else if (beat_i && inc_i) begin
            st_d.addr = st_q.addr + step_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;

    assert_load_takes_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(start_i));

    assert_hold_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !inc_i) |=> $stable(addr_o));

    assert_advance_by_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && beat_i && inc_i) |=> addr_o == $past(addr_o) + $past(step_i));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !beat_i) |=> $stable(addr_o));

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_addr_gen_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] per_start_i,
    input  logic [AW-1:0] mem_start_i,
    input  logic [1:0]    per_width_i,
    input  logic [1:0]    mem_width_i,
    input  logic          per_inc_i,
    input  logic          mem_inc_i,
    input  logic          per_fix4_i,
    input  logic [1:0]    prio_i,
    input  logic          beat_i,
    output logic [AW-1:0] per_addr_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [1:0]    prio_o
);
    localparam int NSIDE = 2;
    localparam int SIDE_PER = 0;
    localparam int SIDE_MEM = 1;

    chan_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.per_inc  = per_inc_i;
            cfg_d.mem_inc  = mem_inc_i;
            cfg_d.per_fix4 = per_fix4_i;
            cfg_d.per_wid  = wid_e'(per_width_i);
            cfg_d.mem_wid  = wid_e'(mem_width_i);
            cfg_d.prio     = prio_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    logic [AW-1:0] start_w [NSIDE];
    logic [AW-1:0] step_w  [NSIDE];
    logic [AW-1:0] addr_w  [NSIDE];
    logic          inc_w   [NSIDE];
    wid_e          wid_w   [NSIDE];

    assign start_w[SIDE_PER] = per_start_i;
    assign start_w[SIDE_MEM] = mem_start_i;
    assign inc_w[SIDE_PER]   = cfg_q.per_inc;
    assign inc_w[SIDE_MEM]   = cfg_q.mem_inc;
    assign wid_w[SIDE_PER]   = cfg_q.per_wid;
    assign wid_w[SIDE_MEM]   = cfg_q.mem_wid;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        dma_step_sel #(.AW(AW)) u_step (
            .wid_i       (wid_w[s]),
            .fix4_i      (cfg_q.per_fix4),
            .allow_fix_i (s == SIDE_PER),
            .step_o      (step_w[s])
        );

        dma_addr_lane #(.AW(AW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load_i),
            .start_i (start_w[s]),
            .beat_i  (beat_i),
            .inc_i   (inc_w[s]),
            .step_i  (step_w[s]),
            .addr_o  (addr_w[s])
        );
    end

    assign per_addr_o = addr_w[SIDE_PER];
    assign mem_addr_o = addr_w[SIDE_MEM];
    assign prio_o     = cfg_q.prio;

    assert_step_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step_w[SIDE_PER]) == 1 && step_w[SIDE_PER] <= AW'(4));

    assert_fixed_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.per_fix4 |-> step_w[SIDE_PER] == AW'(4));

    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !cfg_q.mem_inc) |=> $stable(mem_addr_o));

    assert_prio_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(prio_o));

    assert_cfg_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(cfg_q));

endmodule

// File: tb/sim_dma_addr_gen.sv
`timescale 1ns/1ps
module sim_dma_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_i, beat_i;
    logic [31:0] per_start_i, mem_start_i;
    logic [1:0]  per_width_i, mem_width_i, prio_i;
    logic        per_inc_i, mem_inc_i, per_fix4_i;
    logic [31:0] per_addr_o, mem_addr_o;
    logic [1:0]  prio_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i),
        .per_start_i(per_start_i), .mem_start_i(mem_start_i),
        .per_width_i(per_width_i), .mem_width_i(mem_width_i),
        .per_inc_i(per_inc_i), .mem_inc_i(mem_inc_i), .per_fix4_i(per_fix4_i),
        .prio_i(prio_i), .beat_i(beat_i),
        .per_addr_o(per_addr_o), .mem_addr_o(mem_addr_o), .prio_o(prio_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] step_of(input logic [1:0] w);
        return (w == 2'd0) ? 32'd1 : (w == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] ep, em, np, nm, sp, sm;
        logic [1:0]  pr;
        string       pt, mt;
        rst_n = 1'b0; load_i = 1'b0; beat_i = 1'b0;
        per_start_i = '0; mem_start_i = '0; per_width_i = '0; mem_width_i = '0;
        per_inc_i = 1'b0; mem_inc_i = 1'b0; per_fix4_i = 1'b0; prio_i = '0;
        repeat (3) tick();
        chk("R1 per reset", per_addr_o, 32'd0);
        chk("R1 mem reset", mem_addr_o, 32'd0);
        chk("R1 prio reset", {30'd0, prio_o}, 32'd0);
        rst_n = 1'b1;
        tick();

        for (int idx = 0; idx < 128; idx++) begin
            logic [1:0] pw, mw;
            logic pi, mi, pf;
            pw = idx[1:0]; mw = idx[3:2]; pi = idx[4]; mi = idx[5]; pf = idx[6];
            sp = (idx % 3 == 0) ? 32'hFFFF_FFF8 + 32'(idx % 4) : 32'h1000_0000 + 32'(idx * 64);
            sm = (idx % 4 == 1) ? 32'hFFFF_FFFC : 32'h2000_0000 + 32'(idx * 32);
            pr = 2'(idx * 3);
            per_start_i = sp; mem_start_i = sm; per_width_i = pw; mem_width_i = mw;
            per_inc_i = pi; mem_inc_i = mi; per_fix4_i = pf; prio_i = pr;
            load_i = 1'b1;
            tick();
            load_i = 1'b0;
            per_start_i = ~sp; mem_start_i = ~sm; per_width_i = ~pw; mem_width_i = ~mw;
            per_inc_i = ~pi; mem_inc_i = ~mi; per_fix4_i = ~pf; prio_i = ~pr;
            chk("R2 per load", per_addr_o, sp);
            chk("R2 mem load", mem_addr_o, sm);
            chk("R10 prio load", {30'd0, prio_o}, {30'd0, pr});
            ep = sp; em = sm;
            pt = !pi ? "R3" : (pf ? "R6" : "R5");
            mt = !mi ? "R4" : "R7";
            for (int k = 1; k <= 5; k++) begin
                beat_i = 1'b1;
                tick();
                beat_i = 1'b0;
                np = pi ? ep + (pf ? 32'd4 : step_of(pw)) : ep;
                nm = mi ? em + step_of(mw) : em;
                chk((np < ep) ? {"R9 ", pt} : (k == 1) ? {"R11 ", pt} : pt, per_addr_o, np);
                chk((nm < em) ? {"R9 ", mt} : (k == 1) ? {"R11 ", mt} : mt, mem_addr_o, nm);
                ep = np; em = nm;
                tick();
                chk("R8 per idle", per_addr_o, ep);
                chk("R8 mem idle", mem_addr_o, em);
            end
            chk("R10 prio held", {30'd0, prio_o}, {30'd0, pr});
        end

        per_start_i = 32'h0000_0100; mem_start_i = 32'h0000_0200;
        per_width_i = 2'd2; mem_width_i = 2'd2; per_inc_i = 1'b1; mem_inc_i = 1'b1;
        per_fix4_i = 1'b0; prio_i = 2'd3;
        load_i = 1'b1; beat_i = 1'b1;
        tick();
        load_i = 1'b0; beat_i = 1'b0;
        chk("R2 per load over beat", per_addr_o, 32'h0000_0100);
        chk("R2 mem load over beat", mem_addr_o, 32'h0000_0200);
        chk("R10 prio very high", {30'd0, prio_o}, 32'd3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule